// File: doc/BRIEF.md
# Oversampling Serial Receiver and Transmitter with Noise Detection

This block is an asynchronous serial link endpoint for host communication. It pairs a transmitter and a receiver that share one oversampling tick. A 16-bit divisor sets the tick rate; one bit on the line lasts sixteen ticks. A frame is one low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one high stop bit. Parity is enabled with `par_en` and is odd or even as set by `par_odd`.

The receiver passes the line through a two-flop synchronizer. It looks for a low level on each tick and starts counting ticks from that point. It takes three samples of every bit, start and stop bits included, on ticks 7, 8 and 9 of that bit, so the samples are one sixteenth of a bit apart. The bit value is the majority of the three samples. A frame in which any bit's samples disagree is still delivered, with a noise flag set. Framing and parity errors are flagged too. Parity settings are captured when the start bit is detected.

Both byte interfaces use valid/ready. The transmitter raises `tx_ready` only while idle, and a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. Once the receiver raises `rx_valid`, it holds the byte and its flags steady until `rx_ready` is seen high on a clock edge. A frame that finishes while the previous byte is still waiting is discarded, and the waiting byte is kept. The receiver cannot stall the serial line.

Top module: `uart_os16`

## Requirements
- R1: The tick occurs once every `baud_div` clock cycles, and a divisor of 0 acts as 1. Every transmitted bit lasts 16 ticks, so a 10-bit frame at divisor 4 keeps `tx_ready` low for 637 to 640 cycles.
- R2: The transmitter sends a start bit of 0, the data bits LSB first, then the parity bit when `par_en`=1, then a stop bit of 1. With `par_en`=0 there is no parity bit. When idle, `txd` is 1.
- R3: The receiver samples each bit on ticks 7, 8 and 9, counted from the start-detection tick (tick 0). The bit value is the majority of the three samples. Data bits fill `rx_data` LSB first.
- R4: `rx_noise` is 1 when the three samples of any bit in the frame disagree, start and stop bits included. The byte is still delivered, with the majority values.
- R5: `rx_frame_err` is 1 when the majority value of the stop bit is 0.
- R6: With `par_en`=1, the parity bit p must satisfy XOR(data) XOR p = `par_odd`. A mismatch sets `rx_par_err`. With `par_en`=0, `rx_par_err` is 0.
- R7: A start bit whose majority value is 1 is dropped as a false start, and no byte is produced.
- R8: While `rx_valid`=1 and `rx_ready`=0, `rx_data` and the flags stay unchanged. A frame that finishes in that state is discarded. A clock edge with `rx_ready`=1 clears `rx_valid`.
- R9: `tx_ready` is 1 only while the transmitter is idle. After an accepting edge, `tx_ready` is 0 and `txd` carries the start bit from the next cycle on.
- R10: After reset, `txd`=1, `tx_ready`=1, `rx_valid`=0 and all receive flags are 0.
- R11: At divisor 1, with the first low cycle of an n-bit frame on `rxd` entering the synchronizer at edge E, `rx_valid` rises at edge E+16n-5. This is the edge that handles tick 9 of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| par_en | input | 1 | Adds or expects a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmitter is idle and can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` and the flags are valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_noise | output | 1 | Sample disagreement in the held frame |
| rx_frame_err | output | 1 | Stop bit of the held frame was 0 |
| rx_par_err | output | 1 | Parity mismatch in the held frame |

## Verification
At divisor 1 the tick phase is fixed, so the bench drives `rxd` cycle by cycle at falling edges. One-cycle glitches land on exactly the sample ticks 7, 8 or 9 of a chosen bit, or deliberately miss them. The bench checks that `rx_valid` is still 0 one cycle before edge E+16n-5 and is 1 just after it. On the transmit side, the byte is accepted at an edge A. Each bit b is checked at the falling edge after A+16b+8, and `tx_ready` is checked to be 0 after A+175 and 1 after A+176 for an 11-bit frame. The loopback run at divisor 4 has an unknown tick phase, so there the busy time is checked against a four-cycle window instead of an exact cycle.

// File: rtl/uart_os16_pkg.sv
package uart_os16_pkg;

  localparam int OVS       = 16;
  localparam int OVS_W     = $clog2(OVS);
  localparam int SMP_FIRST = 7;
  localparam int SMP_MID   = 8;
  localparam int SMP_LAST  = 9;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic agree3(input logic a, input logic b, input logic c);
    return (a == b) && (b == c);
  endfunction

endpackage

// File: rtl/uart_os16_baud.sv
module uart_os16_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim = (div == '0) ? '0 : div - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1) |=> (!tick || div <= 1)); // R1

endmodule

// File: rtl/uart_os16_rx.sv
module uart_os16_rx
  import uart_os16_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 rx_noise,
  output logic                 rx_frame_err,
  output logic                 rx_par_err
);

  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  logic [1:0]           sync_q;
  logic                 rxs;
  rx_state_t            state;
  logic [OVS_W-1:0]     ocnt;
  logic [BIT_W-1:0]     bidx;
  logic [1:0]           smp;
  logic [DATA_BITS-1:0] shreg;
  logic                 noise_acc;
  logic                 perr_acc;
  logic                 pen_l;
  logic                 podd_l;
  logic                 at_mid;
  logic                 at_end;
  logic                 vote;
  logic                 dis;
  logic                 finish;

  // two-flop synchronizer on the serial line (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxs = sync_q[1];

  always_comb begin
    at_mid = tick && (state != RX_IDLE) && (ocnt == OVS_W'(SMP_LAST));
    at_end = tick && (state != RX_IDLE) && (ocnt == OVS_W'(OVS - 1));
    vote   = maj3(smp[0], smp[1], rxs);
    dis    = !agree3(smp[0], smp[1], rxs);
    finish = at_mid && (state == RX_STOP);
  end

  // frame sequencer: samples on ticks 7, 8, 9 of every bit (R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      ocnt      <= '0;
      bidx      <= '0;
      smp       <= 2'b11;
      shreg     <= '0;
      noise_acc <= 1'b0;
      perr_acc  <= 1'b0;
      pen_l     <= 1'b0;
      podd_l    <= 1'b0;
    end else if (tick) begin
      if (state == RX_IDLE) begin
        if (!rxs) begin
          state     <= RX_START;
          ocnt      <= OVS_W'(1);
          bidx      <= '0;
          noise_acc <= 1'b0;
          perr_acc  <= 1'b0;
          pen_l     <= par_en;
          podd_l    <= par_odd;
        end
      end else begin
        ocnt <= ocnt + 1'b1;
        if (ocnt == OVS_W'(SMP_FIRST)) smp[0] <= rxs;
        if (ocnt == OVS_W'(SMP_MID))   smp[1] <= rxs;
        if (at_mid) begin
          noise_acc <= noise_acc | dis;
          unique case (state)
            RX_START: if (vote) state <= RX_IDLE;   // false start (R7)
            RX_DATA:  shreg <= {vote, shreg[DATA_BITS-1:1]};
            RX_PAR:   perr_acc <= ((^shreg) ^ vote) != podd_l;
            RX_STOP:  state <= RX_IDLE;
            default:  state <= RX_IDLE;
          endcase
        end
        if (at_end) begin
          unique case (state)
            RX_START: state <= RX_DATA;
            RX_DATA: begin
              bidx <= bidx + 1'b1;
              if (bidx == LAST_BIT) state <= pen_l ? RX_PAR : RX_STOP;
            end
            RX_PAR:   state <= RX_STOP;
            default:  state <= RX_IDLE;
          endcase
        end
      end
    end
  end

  // output holding register with back-pressure (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_noise     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
    end else if (finish && (!rx_valid || rx_ready)) begin
      rx_valid     <= 1'b1;
      rx_data      <= shreg;
      rx_noise     <= noise_acc | dis;
      rx_frame_err <= !vote;
      rx_par_err   <= perr_acc;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_noise))); // R8

  AST_RX_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !finish) |=> !rx_valid); // R8

  AST_RX_NO_PERR_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !pen_l) |-> !perr_acc); // R6

endmodule

// File: rtl/uart_os16_tx.sv
module uart_os16_tx
  import uart_os16_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 txd
);

  localparam int FW  = DATA_BITS + 3;
  localparam int FCW = $clog2(FW);

  logic [FW-1:0]    sh;
  logic [FCW-1:0]   bcnt;
  logic [FCW-1:0]   last;
  logic [OVS_W-1:0] tcnt;
  logic             busy;
  logic             accept;

  assign accept   = tx_valid && !busy;
  assign tx_ready = !busy;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      bcnt <= '0;
      last <= '0;
      tcnt <= '0;
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      bcnt <= '0;
      tcnt <= '0;
      if (par_en) begin
        sh   <= {1'b1, (^tx_data) ^ par_odd, tx_data, 1'b0};
        last <= FCW'(FW - 1);
      end else begin
        sh   <= {2'b11, tx_data, 1'b0};
        last <= FCW'(FW - 2);
      end
    end else if (busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == OVS_W'(OVS - 1)) begin
        sh <= {1'b1, sh[FW-1:1]};
        if (bcnt == last) busy <= 1'b0;
        else              bcnt <= bcnt + 1'b1;
      end
    end
  end

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !txd)); // R9

endmodule

// File: rtl/uart_os16.sv
module uart_os16 #(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     baud_div,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rxd,
  output logic                 txd,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 rx_noise,
  output logic                 rx_frame_err,
  output logic                 rx_par_err
);

  logic tick;

  uart_os16_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (baud_div),
    .tick  (tick)
  );

  uart_os16_rx #(.DATA_BITS(DATA_BITS)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .rxd          (rxd),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_noise     (rx_noise),
    .rx_frame_err (rx_frame_err),
    .rx_par_err   (rx_par_err)
  );

  uart_os16_tx #(.DATA_BITS(DATA_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

endmodule

// File: tb/uart_os16_bench.sv
module uart_os16_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic        par_en = 1'b0;
  logic        par_odd = 1'b0;
  logic        rxd_drv = 1'b1;
  logic        loop_en = 1'b0;
  logic        rxd;
  logic        txd;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        rx_noise;
  logic        rx_frame_err;
  logic        rx_par_err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_drv;

  uart_os16 u_uart_os16 (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .par_en(par_en), .par_odd(par_odd),
    .rxd(rxd), .txd(txd), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_noise(rx_noise),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  typedef struct packed {
    logic [7:0] data;
    logic       pen;
    logic       podd;
    logic       pflip;
    logic       stopv;
    logic [7:0] gpos;
    logic [1:0] glen;
    logic [7:0] edata;
    logic       en;
    logic       ef;
    logic       ep;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'd255, 2'd0, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 8'd255, 2'd0, 8'h3C, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 8'd255, 2'd0, 8'h3C, 1'b0, 1'b0, 1'b0},
    '{8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 8'd255, 2'd0, 8'h81, 1'b0, 1'b0, 1'b1},
    '{8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 2'd0, 8'h55, 1'b0, 1'b1, 1'b0},
    '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 8'd56,  2'd1, 8'h0F, 1'b1, 1'b0, 1'b0},
    '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 8'd51,  2'd1, 8'h0F, 1'b0, 1'b0, 1'b0},
    '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 8'd56,  2'd2, 8'h0B, 1'b1, 1'b0, 1'b0},
    '{8'h96, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8,   2'd1, 8'h96, 1'b1, 1'b0, 1'b0},
    '{8'h42, 1'b0, 1'b0, 1'b0, 1'b1, 8'd153, 2'd1, 8'h42, 1'b1, 1'b0, 1'b0},
    '{8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'd255, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{8'h18, 1'b0, 1'b0, 1'b0, 1'b1, 8'd152, 2'd2, 8'h18, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives one frame on rxd at divisor 1; optional timing check of rx_valid (R11)
  task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                            input logic pflip, input logic stopv, input int gpos,
                            input int glen, input bit tcheck);
    logic [10:0] fr;
    int n;
    logic early;
    logic late;
    n = pen ? 11 : 10;
    fr = '1;
    fr[0] = 1'b0;
    fr[8:1] = d;
    if (pen) begin
      fr[9]  = (^d) ^ podd ^ pflip;
      fr[10] = stopv;
    end else begin
      fr[9] = stopv;
    end
    early = 1'b0;
    late = 1'b0;
    for (int j = 0; j < 16 * n; j++) begin
      logic b;
      @(negedge clk);
      if (j == 16 * n - 5) early = rx_valid;
      if (j == 16 * n - 4) late = rx_valid;
      b = fr[j / 16];
      if (glen != 0 && j >= gpos && j < gpos + glen) b = ~b;
      rxd_drv = b;
    end
    @(negedge clk);
    rxd_drv = 1'b1;
    repeat (24) @(negedge clk);
    if (tcheck) begin
      chk(early == 1'b0, "R11", "rx_valid one cycle before due", int'(early), 0);
      chk(late == 1'b1, "R11", "rx_valid on due edge", int'(late), 1);
    end
  endtask

  task automatic consume();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(txd == 1'b1, "R10", "txd idle", int'(txd), 1);
    chk(tx_ready == 1'b1, "R10", "tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R10", "rx_valid", int'(rx_valid), 0);
    chk({rx_noise, rx_frame_err, rx_par_err} == 3'b000, "R10", "rx flags",
        int'({rx_noise, rx_frame_err, rx_par_err}), 0);
    repeat (10) @(negedge clk);

    // vector table: R3 R4 R5 R6 R11
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      par_en = v.pen;
      par_odd = v.podd;
      send_frame(v.data, v.pen, v.podd, v.pflip, v.stopv, int'(v.gpos), int'(v.glen), 1'b1);
      chk(rx_data == v.edata, "R3", $sformatf("vec%0d data", i), int'(rx_data), int'(v.edata));
      chk(rx_noise == v.en, "R4", $sformatf("vec%0d noise", i), int'(rx_noise), int'(v.en));
      chk(rx_frame_err == v.ef, "R5", $sformatf("vec%0d frame_err", i),
          int'(rx_frame_err), int'(v.ef));
      chk(rx_par_err == v.ep, "R6", $sformatf("vec%0d par_err", i),
          int'(rx_par_err), int'(v.ep));
      consume();
      chk(rx_valid == 1'b0, "R8", $sformatf("vec%0d cleared", i), int'(rx_valid), 0);
    end
    par_en = 1'b0;
    par_odd = 1'b0;

    // R7: false start of two low cycles
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (2) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (200) @(negedge clk);
    chk(rx_valid == 1'b0, "R7", "false start dropped", int'(rx_valid), 0);

    // R8: second frame arrives while first is held
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
    chk(rx_valid == 1'b1, "R8", "held valid", int'(rx_valid), 1);
    chk(rx_data == 8'h11, "R8", "held byte kept", int'(rx_data), 8'h11);
    consume();
    chk(rx_valid == 1'b0, "R8", "dropped frame not delivered", int'(rx_valid), 0);

    // R2 R9 R1: transmit 0x6B with odd parity at divisor 1
    par_en = 1'b1;
    par_odd = 1'b1;
    begin
      logic [10:0] ef;
      ef = {1'b1, (^8'h6B) ^ 1'b1, 8'h6B, 1'b0};
      @(negedge clk);
      tx_data = 8'h6B;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0, "R9", "tx_ready after accept", int'(tx_ready), 0);
      repeat (8) @(negedge clk);
      for (int b = 0; b < 11; b++) begin
        if (b != 0) repeat (16) @(negedge clk);
        chk(txd == ef[b], "R2", $sformatf("tx bit %0d", b), int'(txd), int'(ef[b]));
      end
      repeat (7) @(negedge clk);
      chk(tx_ready == 1'b0, "R1", "busy through last bit", int'(tx_ready), 0);
      @(negedge clk);
      chk(tx_ready == 1'b1, "R1", "idle after 176 cycles", int'(tx_ready), 1);
      chk(txd == 1'b1, "R2", "idle line high", int'(txd), 1);
    end

    // R1: loopback at divisor 4 without parity
    par_en = 1'b0;
    par_odd = 1'b0;
    baud_div = 16'd4;
    loop_en = 1'b1;
    repeat (20) @(negedge clk);
    begin
      int busy_cnt;
      int waitc;
      busy_cnt = 0;
      tx_data = 8'hC3;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!tx_ready && busy_cnt < 2000) begin
        busy_cnt++;
        @(negedge clk);
      end
      chk(busy_cnt >= 637 && busy_cnt <= 640, "R1", "tx frame length div4", busy_cnt, 640);
      waitc = 0;
      while (!rx_valid && waitc < 200) begin
        waitc++;
        @(negedge clk);
      end
      chk(rx_valid == 1'b1, "R1", "loopback delivered", int'(rx_valid), 1);
      chk(rx_data == 8'hC3, "R3", "loopback byte", int'(rx_data), 8'hC3);
      chk({rx_noise, rx_frame_err, rx_par_err} == 3'b000, "R4", "loopback clean",
          int'({rx_noise, rx_frame_err, rx_par_err}), 0);
      consume();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule